// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a vector of interrupt sources into a single processor request line. Every source passes through a programmable polarity stage. Software then chooses, per source, whether the status it sees is the live level or a latch that records any change of that level. An enable mask, written through separate set and clear addresses, qualifies that status. Each source carries a 3-bit priority, where a smaller value is more urgent. A combinational arbiter names the most urgent enabled source whose priority lies below a 4-bit threshold.

The processor services interrupts through two reads. A peek read only reports the winning source number. A take read also saves the threshold in a one-deep slot and raises the threshold to the winner's priority. A later acknowledge read returns the saved value and restores it as the threshold. In this way, a handler blocks sources of equal or lower urgency while it runs.

The register interface is word addressed. Reads return data combinationally in the same cycle as the read strobe. Writes, and the side effects of reads, take effect at the next rising clock edge.

Top module: `prio_intc`

## Requirements
- R1: After reset the enable mask is 0, the polarity register is all 1s, the sticky-select register is 0, every priority is 7, the threshold is 8 and `irq_o` is low.
- R2: A write to EN_SET (word 2) sets the mask bits that are 1 in the data. A write to EN_CLR (word 3) clears them. A read of either address returns the mask.
- R3: A read of MASKED (word 0) returns the selected status (word 1) AND the enable mask.
- R4: A 0 bit in POLARITY (word 4, read/write) inverts the matching source before status and arbitration. A 1 bit passes the source unchanged.
- R5: For each bit set in STICKY_SEL (word 5, read/write), STATUS reads a latch instead of the level. The latch sets on any change of the polarity-corrected input. A write of 1s to STATUS clears latch bits. A set event in the same cycle as the clear wins.
- R6: Each source has a priority register at word 16+n (bits 2:0, read/write). The winner is the eligible source with the smallest priority value. On a tie, the lower source number wins.
- R7: A source is eligible only when it is set in MASKED and its priority is below the threshold. `irq_o` is high exactly when some source is eligible.
- R8: A read of PEEK (word 6) returns the winner's number, or N_SRC (32) when none is eligible. It changes no state.
- R9: A read of TAKE (word 7) returns the same value as PEEK. When a winner exists, the read also copies the threshold into the save slot and loads the winner's priority as the threshold. With no winner, both stay unchanged.
- R10: A read of ACK (word 8) returns the save slot and loads the slot into the threshold. The slot itself keeps its value.
- R11: THRESH (word 9, bits 3:0) is readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Interrupt source levels |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe, which qualifies read side effects |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | N_SRC | Write data |
| bus_rdata_o | output | N_SRC | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Processor interrupt request |

## Verification
The hardest case to reach from the ports is a sticky latch set event that lands on the same clock edge as a clear write to that bit. The bench lines these up by changing the source level and issuing the status write on the same post-edge drive, so that both take effect on one rising edge. A second hard case is nested service. Two take reads in a row, with a new more urgent source raised between them, drive the threshold down twice. The one-deep slot must then return only the intermediate threshold on both later acknowledges. A take read with no eligible source is also exercised, to show that the slot survives it.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned A_MASKED  = 0;
  localparam int unsigned A_STATUS  = 1;
  localparam int unsigned A_EN_SET  = 2;
  localparam int unsigned A_EN_CLR  = 3;
  localparam int unsigned A_POL     = 4;
  localparam int unsigned A_STK_SEL = 5;
  localparam int unsigned A_PEEK    = 6;
  localparam int unsigned A_TAKE    = 7;
  localparam int unsigned A_ACK     = 8;
  localparam int unsigned A_THRESH  = 9;
  localparam int unsigned A_PRIO    = 16;
endpackage

// File: rtl/intc_status.sv
module intc_status #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] pol_i,
  input  logic [N_SRC-1:0] sel_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] lvl, prev_q, sticky_q, chg;

  assign lvl = src_i ^ ~pol_i;
  assign chg = lvl ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      sticky_q <= '0;
    end else begin
      prev_q   <= lvl;
      sticky_q <= (sticky_q & ~clr_i) | chg;  // set beats clear
    end
  end

  assign status_o = (sel_i & sticky_q) | (~sel_i & lvl);

  a_r5_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg != '0) |=> ((sticky_q & $past(chg)) == $past(chg)));
  a_r5_sticky_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~chg) != '0) |=> ((sticky_q & $past(clr_i & ~chg)) == '0));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned THR_W = PRIO_W + 1,
  localparam int unsigned IDX_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0]             masked_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [THR_W-1:0]             thr_i,
  output logic                         found_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [PRIO_W-1:0]            prio_o
);
  logic [N_SRC-1:0] elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig[g] = masked_i[g] && ({1'b0, prio_i[g]} < thr_i);
  end

  always_comb begin
    found_o = 1'b0;
    prio_o  = '1;
    idx_o   = IDX_W'(N_SRC);
    for (int i = 0; i < N_SRC; i++) begin
      // strict compare keeps the lower index on ties
      if (elig[i] && (!found_o || prio_i[i] < prio_o)) begin
        found_o = 1'b1;
        prio_o  = prio_i[i];
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_thresh.sv
module intc_thresh #(
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned THR_W = PRIO_W + 1,
  localparam logic [THR_W-1:0] THR_RST = THR_W'(1 << PRIO_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              ack_i,
  input  logic              wr_i,
  input  logic [THR_W-1:0]  wdata_i,
  input  logic [PRIO_W-1:0] win_prio_i,
  output logic [THR_W-1:0]  thr_o,
  output logic [THR_W-1:0]  slot_o
);
  logic [THR_W-1:0] thr_q, slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= THR_RST;
      slot_q <= THR_RST;
    end else if (take_i) begin
      slot_q <= thr_q;
      thr_q  <= {1'b0, win_prio_i};
    end else if (ack_i) begin
      thr_q  <= slot_q;
    end else if (wr_i) begin
      thr_q  <= wdata_i;
    end
  end

  assign thr_o  = thr_q;
  assign slot_o = slot_q;

  a_r9_take_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (thr_q == {1'b0, $past(win_prio_i)}) && (slot_q == $past(thr_q)));
  a_r10_ack_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !take_i) |=> (thr_q == $past(slot_q)) && $stable(slot_q));
  a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !ack_i && !wr_i) |=> $stable(thr_q) && $stable(slot_q));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned THR_W  = PRIO_W + 1,
  localparam int unsigned IDX_W  = $clog2(N_SRC + 1),
  localparam int unsigned SEL_W  = $clog2(N_SRC),
  localparam int unsigned ADDR_W = $clog2(A_PRIO + N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N_SRC-1:0]  bus_wdata_i,
  output logic [N_SRC-1:0]  bus_rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0]             mask_q, pol_q, sel_q, status, masked, clr;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [THR_W-1:0]             thr, slot;
  logic                         found;
  logic [IDX_W-1:0]             win_idx;
  logic [PRIO_W-1:0]            win_prio;
  logic                         wr_hit_set, wr_hit_clr, take, ack;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
    return a == ADDR_W'(r);
  endfunction

  assign wr_hit_set = bus_we_i && hit(bus_addr_i, A_EN_SET);
  assign wr_hit_clr = bus_we_i && hit(bus_addr_i, A_EN_CLR);
  assign clr  = (bus_we_i && hit(bus_addr_i, A_STATUS)) ? bus_wdata_i : '0;
  assign take = bus_re_i && hit(bus_addr_i, A_TAKE) && found;
  assign ack  = bus_re_i && hit(bus_addr_i, A_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pol_q  <= '1;
      sel_q  <= '0;
    end else if (bus_we_i) begin
      if (wr_hit_set) mask_q <= mask_q | bus_wdata_i;
      if (wr_hit_clr) mask_q <= mask_q & ~bus_wdata_i;
      if (hit(bus_addr_i, A_POL)) pol_q <= bus_wdata_i;
      if (hit(bus_addr_i, A_STK_SEL)) sel_q <= bus_wdata_i;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[g] <= '1;
      else if (bus_we_i && hit(bus_addr_i, A_PRIO + g)) prio_q[g] <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  intc_status #(.N_SRC(N_SRC)) i_status (
    .clk_i, .rst_ni, .src_i, .pol_i(pol_q), .sel_i(sel_q), .clr_i(clr), .status_o(status)
  );

  assign masked = status & mask_q;

  intc_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_arbiter (
    .masked_i(masked), .prio_i(prio_q), .thr_i(thr),
    .found_o(found), .idx_o(win_idx), .prio_o(win_prio)
  );

  intc_thresh #(.PRIO_W(PRIO_W)) i_thresh (
    .clk_i, .rst_ni, .take_i(take), .ack_i(ack),
    .wr_i(bus_we_i && hit(bus_addr_i, A_THRESH)),
    .wdata_i(bus_wdata_i[THR_W-1:0]), .win_prio_i(win_prio),
    .thr_o(thr), .slot_o(slot)
  );

  assign irq_o = found;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i >= ADDR_W'(A_PRIO)) begin
      for (int i = 0; i < N_SRC; i++)
        if (hit(bus_addr_i, A_PRIO + i)) bus_rdata_o = N_SRC'(prio_q[i]);
    end else begin
      case (int'(bus_addr_i))
        A_MASKED:           bus_rdata_o = masked;
        A_STATUS:           bus_rdata_o = status;
        A_EN_SET, A_EN_CLR: bus_rdata_o = mask_q;
        A_POL:              bus_rdata_o = pol_q;
        A_STK_SEL:          bus_rdata_o = sel_q;
        A_PEEK, A_TAKE:     bus_rdata_o = N_SRC'(win_idx);
        A_ACK:              bus_rdata_o = N_SRC'(slot);
        A_THRESH:           bus_rdata_o = N_SRC'(thr);
        default:            bus_rdata_o = '0;
      endcase
    end
  end

  a_r2_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_set |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));
  a_r2_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_clr |=> ((mask_q & $past(bus_wdata_i)) == '0));
  a_r7_winner_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (({1'b0, prio_q[win_idx[SEL_W-1:0]]} < thr) && masked[win_idx[SEL_W-1:0]]));
  a_r8_none_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (win_idx == IDX_W'(N_SRC)));
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
  localparam time CLK_PERIOD = 10ns;
  localparam int N = 32;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0, wdata = '0, rdata;
  logic we = 0, re = 0, irq;
  logic [5:0] addr = '0;
  int checks = 0, fails = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc i_prio_intc (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    we = 1; addr = 6'(a); wdata = d;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    re = 1; addr = 6'(a);
    #1 v = rdata;
    @(posedge clk); #1;
    re = 0;
  endtask

  task automatic rdchk(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    rdchk("R1 mask", 2, 0);
    rdchk("R1 pol", 4, 32'hFFFF_FFFF);
    rdchk("R1 sel", 5, 0);
    rdchk("R1 thr", 9, 8);
    rdchk("R1 prio5", 21, 7);
    chk("R1 irq", 32'(irq), 0);
    rdchk("R8 peek none", 6, 32);
  endtask

  task automatic t_mask;
    wr(2, 32'h0000_00F0);
    wr(2, 32'h0000_0001);
    rdchk("R2 clr reads mask", 3, 32'h0000_00F1);
    wr(3, 32'h0000_0030);
    rdchk("R2 set reads mask", 2, 32'h0000_00C1);
  endtask

  task automatic t_polarity;
    src = 32'h0000_0003;
    rdchk("R4 raw", 1, 32'h3);
    rdchk("R3 masked", 0, 32'h1);
    wr(4, 32'hFFFF_FFFD);
    rdchk("R4 inverted", 1, 32'h1);
    src = 32'h0;
    rdchk("R4 inverted low", 1, 32'h2);
    wr(4, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
  endtask

  task automatic t_sticky;
    wr(5, 32'h0000_0100);
    wr(1, 32'hFFFF_FFFF);
    rdchk("R5 cleared", 1, 0);
    src[8] = 1; @(posedge clk); #1;
    src[8] = 0;
    rdchk("R5 latched", 1, 32'h100);
    wr(1, 32'h100);
    rdchk("R5 clear write", 1, 0);
    src[8] = 1; wr(1, 32'h100);  // change and clear on one edge
    rdchk("R5 set wins", 1, 32'h100);
    src[8] = 0; @(posedge clk); #1;
    wr(1, 32'hFFFF_FFFF);
    wr(5, 0);
    rdchk("R5 raw again", 1, 0);
  endtask

  task automatic t_priority;
    wr(2, 32'hFFFF_FFFF);
    wr(16 + 3, 5); wr(16 + 10, 2); wr(16 + 20, 2);
    rdchk("R6 prio read", 16 + 10, 2);
    src = (32'h1 << 3) | (32'h1 << 10) | (32'h1 << 20);
    rdchk("R6 tie lower", 6, 10);
    chk("R7 irq on", 32'(irq), 1);
    wr(16 + 20, 1);
    rdchk("R6 more urgent", 6, 20);
    src[20] = 0;
    rdchk("R6 fallback", 6, 10);
  endtask

  task automatic t_threshold;
    wr(9, 2);
    rdchk("R11 thr rd", 9, 2);
    chk("R7 irq off", 32'(irq), 0);
    rdchk("R7 none", 6, 32);
    wr(9, 8);
    chk("R7 irq back", 32'(irq), 1);
  endtask

  task automatic t_take_ack;
    rdchk("R8 peek", 6, 10);
    rdchk("R8 peek no effect", 9, 8);
    rdchk("R9 take", 7, 10);
    rdchk("R9 thr raised", 9, 2);
    chk("R9 irq blocked", 32'(irq), 0);
    wr(16 + 7, 0);
    src[7] = 1;
    #1 chk("R7 urgent irq", 32'(irq), 1);
    rdchk("R9 take2", 7, 7);
    rdchk("R9 thr0", 9, 0);
    rdchk("R10 ack", 8, 2);
    rdchk("R10 thr restored", 9, 2);
    rdchk("R10 ack again", 8, 2);
    rdchk("R10 thr stays", 9, 2);
  endtask

  task automatic t_empty_take;
    wr(9, 8);
    src = '0;
    rdchk("R9 take none", 7, 32);
    rdchk("R9 thr kept", 9, 8);
    rdchk("R9 slot kept", 8, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 3) rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_mask();
    t_polarity();
    t_sticky();
    t_priority();
    t_threshold();
    t_take_ack();
    t_empty_take();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule